// File: doc/BRIEF.md
# Generation-Bit Egress Descriptor Ring Consumer

This block drains a circular ring of two-word egress descriptors that software places in local memory. Software announces new work by writing its tail index into a doorbell register. The consumer then reads the entry at its head index. It accepts that entry only when the entry's generation bit equals the value the consumer currently expects. Software flips the generation bit it writes on every pass around the ring. The consumer flips its expected value whenever its head wraps. As a result, a stale entry from the previous lap is never mistaken for new work, and no separate valid flag or count is needed.

An accepted descriptor is decoded and offered to a downstream byte mover on a valid/ready port. The decoded descriptor carries:
- the transfer length;
- an end-of-packet marker;
- a no-send flag and a move-data qualifier;
- the checksum controls;
- the buffer address, stack index and buffer size in bytes;
- a buffer-release request.

A descriptor whose checksum fields are set while checksum is disabled is dropped and flagged as malformed. The ring memory read port has a fixed latency of one cycle.

Top module: `desc_ring_consumer`

## Requirements
- R1: After reset the consumer presents nothing (out_valid=0), issues no memory read and raises no malformed flag; its head index is 0 and its expected generation value is 1.
- R2: An entry is consumed only if bit 0 of its control word (memory word 2*index) equals the expected generation value. Otherwise it is not presented, and it is re-read until it matches.
- R3: The expected generation value inverts each time the head index moves from entry DEPTH-1 to entry 0, so entries of the second lap are accepted with generation bit 0.
- R4: A write with tail_we loads tail_idx into the doorbell register. No ring read is issued while the head index equals the doorbell value.
- R5: out_eop follows bit 11 of the control word and is high only on the descriptor that carries that bit.
- R6: When bit 9 of the control word (no-send) is set, out_nosend=1 and out_move=0. The descriptor is still presented, and its buffer release still follows R7 and R9.
- R7: When the transfer size (control word bits 29:16, 14 bits) is zero, out_move=0, out_rel=0, and out_va, out_stack and out_buf_bytes read zero.
- R8: out_buf_bytes decodes the size code in bits 61:59 of the buffer word (memory word 2*index+1). Codes 0 to 7 give 128, 256, 512, 1024, 1664, 4096, 10368 and 16384 bytes.
- R9: out_rel is high only when bit 58 of the buffer word (hardware release) is set and the transfer size is nonzero.
- R10: When bit 8 of the control word (checksum enable) is clear and any bit of 63:32 is set, the entry raises err_malformed for exactly one cycle. It is not presented, and the head index still advances past it.
- R11: While out_valid is high and out_ready is low, out_valid stays high and all descriptor outputs hold their values.
- R12: The outputs map the descriptor words as follows.
  - Checksum enable is control-word bit 8.
  - Checksum destination is bits 39:32.
  - Checksum start is bits 47:40.
  - Checksum seed is bits 63:48.
  - The buffer address is buffer-word bits 41:0.
  - The stack index is buffer-word bits 52:48.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tail_we | input | 1 | Doorbell write strobe |
| tail_idx | input | IDX_W | Software tail index written to the doorbell |
| mem_rd_en | output | 1 | Ring memory read request |
| mem_rd_addr | output | IDX_W+1 | Word address: {index, word select} |
| mem_rd_data | input | 64 | Read data, valid one cycle after the request |
| out_valid | output | 1 | Descriptor offered downstream |
| out_ready | input | 1 | Downstream accepts the descriptor |
| out_len | output | 14 | Transfer size in bytes |
| out_move | output | 1 | Data is to be moved |
| out_eop | output | 1 | Last descriptor of the packet |
| out_nosend | output | 1 | Nothing to send; buffers only |
| out_csum_en | output | 1 | Checksum enable |
| out_csum_start | output | 8 | Checksum start offset |
| out_csum_dest | output | 8 | Checksum destination offset |
| out_csum_seed | output | 16 | Checksum seed |
| out_va | output | 42 | Buffer address |
| out_stack | output | 5 | Buffer stack index |
| out_buf_bytes | output | 15 | Decoded buffer size in bytes |
| out_rel | output | 1 | Buffer-release request |
| err_malformed | output | 1 | One-cycle malformed-entry flag |

## Verification
The bench builds the consumer with IDX_W=2, which gives a four-entry ring. With that ring, eight descriptors cross the wrap point twice. This shows that the expected generation value flips at each wrap and returns to its starting value. The small depth also brings the stale-generation wait and the head advance past a dropped malformed entry within a few dozen cycles. All eight buffer-size codes are covered, along with zero-length, no-send and back-pressured descriptors.

// File: rtl/desc_ring_consumer.sv
module desc_ring_consumer #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tail_we,
  input  logic [IDX_W-1:0] tail_idx,
  output logic             mem_rd_en,
  output logic [IDX_W:0]   mem_rd_addr,
  input  logic [63:0]      mem_rd_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [13:0]      out_len,
  output logic             out_move,
  output logic             out_eop,
  output logic             out_nosend,
  output logic             out_csum_en,
  output logic [7:0]       out_csum_start,
  output logic [7:0]       out_csum_dest,
  output logic [15:0]      out_csum_seed,
  output logic [41:0]      out_va,
  output logic [4:0]       out_stack,
  output logic [14:0]      out_buf_bytes,
  output logic             out_rel,
  output logic             err_malformed
);

  localparam int DEPTH = 1 << IDX_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_W0, ST_W1, ST_OUT} st_t;

  st_t              st;
  logic [IDX_W-1:0] head, tail;
  logic             exp_gen, err_q;
  logic [63:0]      w0, w1;

  logic gen_ok, malformed, has_data, advance;

  function automatic logic [14:0] size_bytes(input logic [2:0] code);
    case (code)
      3'd0: size_bytes = 15'd128;
      3'd1: size_bytes = 15'd256;
      3'd2: size_bytes = 15'd512;
      3'd3: size_bytes = 15'd1024;
      3'd4: size_bytes = 15'd1664;
      3'd5: size_bytes = 15'd4096;
      3'd6: size_bytes = 15'd10368;
      default: size_bytes = 15'd16384;
    endcase
  endfunction

  assign gen_ok    = mem_rd_data[0] == exp_gen;
  assign malformed = !w0[8] && (w0[63:32] != 32'd0);
  assign advance   = (st == ST_W1 && malformed) || (st == ST_OUT && out_ready);

  assign mem_rd_en   = (st == ST_IDLE && head != tail) || (st == ST_W0 && gen_ok);
  assign mem_rd_addr = {head, st == ST_W0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      head    <= '0;
      tail    <= '0;
      exp_gen <= 1'b1;
      err_q   <= 1'b0;
      w0      <= '0;
      w1      <= '0;
    end else begin
      err_q <= 1'b0;
      if (tail_we) tail <= tail_idx;
      if (advance) begin
        head <= (head == LAST) ? '0 : head + 1'b1;
        if (head == LAST) exp_gen <= ~exp_gen;
      end
      case (st)
        ST_IDLE: if (head != tail) st <= ST_W0;
        ST_W0: begin
          if (gen_ok) begin
            w0 <= mem_rd_data;
            st <= ST_W1;
          end else begin
            st <= ST_IDLE;
          end
        end
        ST_W1: begin
          w1 <= mem_rd_data;
          if (malformed) begin
            err_q <= 1'b1;
            st    <= ST_IDLE;
          end else begin
            st <= ST_OUT;
          end
        end
        default: if (out_ready) st <= ST_IDLE;
      endcase
    end
  end

  assign has_data       = w0[29:16] != 14'd0;
  assign out_valid      = st == ST_OUT;
  assign out_len        = w0[29:16];
  assign out_nosend     = w0[9];
  assign out_eop        = w0[11];
  assign out_move       = has_data && !w0[9];
  assign out_csum_en    = w0[8];
  assign out_csum_dest  = w0[39:32];
  assign out_csum_start = w0[47:40];
  assign out_csum_seed  = w0[63:48];
  assign out_va         = has_data ? w1[41:0] : '0;
  assign out_stack      = has_data ? w1[52:48] : '0;
  assign out_buf_bytes  = has_data ? size_bytes(w1[61:59]) : '0;
  assign out_rel        = has_data && w1[58];
  assign err_malformed  = err_q;

endmodule

module desc_ring_consumer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        out_valid,
  input logic        out_ready,
  input logic [13:0] out_len,
  input logic [41:0] out_va,
  input logic        out_eop,
  input logic        out_nosend,
  input logic        out_move,
  input logic        out_rel,
  input logic [14:0] out_buf_bytes,
  input logic        err_malformed
);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_len) && $stable(out_va) && $stable(out_eop));

  assert_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_malformed |-> !out_valid);

  assert_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_malformed |=> !err_malformed);

  assert_nosend_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_nosend |-> !out_move);

  assert_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_len == 14'd0 |-> !out_rel && !out_move && out_buf_bytes == 15'd0);

endmodule

bind desc_ring_consumer desc_ring_consumer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_len(out_len), .out_va(out_va), .out_eop(out_eop), .out_nosend(out_nosend),
  .out_move(out_move), .out_rel(out_rel), .out_buf_bytes(out_buf_bytes),
  .err_malformed(err_malformed)
);

// File: tb/sim_desc_ring_consumer.sv
module sim_desc_ring_consumer;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 2;
  localparam int DEPTH = 1 << IDX_W;
  localparam int NV = 8;

  function automatic logic [63:0] mk0(input logic cs, input logic ns, input logic bd,
                                      input logic [13:0] xf, input logic [7:0] dst,
                                      input logic [7:0] st, input logic [15:0] sd);
    mk0 = {sd, st, dst, 2'b00, xf, 4'b0000, bd, 1'b0, ns, cs, 1'b0, 6'd0, 1'b0};
  endfunction

  function automatic logic [63:0] mk1(input logic [41:0] va, input logic [4:0] stk,
                                      input logic hwb, input logic [2:0] sz);
    mk1 = {2'b00, sz, hwb, 2'b00, 3'b000, stk, 6'd0, va};
  endfunction

  localparam logic [63:0] V_W0 [NV] = '{
    mk0(1'b0, 1'b0, 1'b0, 14'd100,   8'd0, 8'd0, 16'h0000),
    mk0(1'b1, 1'b0, 1'b1, 14'd60,    8'd4, 8'd2, 16'hBEEF),
    mk0(1'b0, 1'b1, 1'b1, 14'd50,    8'd0, 8'd0, 16'h0000),
    mk0(1'b0, 1'b0, 1'b0, 14'd0,     8'd0, 8'd0, 16'h0000),
    mk0(1'b1, 1'b0, 1'b0, 14'd16383, 8'd9, 8'd7, 16'h1234),
    mk0(1'b0, 1'b0, 1'b0, 14'd1,     8'd0, 8'd0, 16'h0000),
    mk0(1'b0, 1'b0, 1'b1, 14'd200,   8'd0, 8'd0, 16'h0000),
    mk0(1'b0, 1'b0, 1'b0, 14'd300,   8'd0, 8'd0, 16'h0000)
  };
  localparam logic [63:0] V_W1 [NV] = '{
    mk1(42'h123,        5'd3,  1'b1, 3'd0),
    mk1(42'h2AAAA,      5'd1,  1'b0, 3'd3),
    mk1(42'h4000,       5'd7,  1'b1, 3'd4),
    mk1(42'h3FF,        5'd9,  1'b1, 3'd5),
    mk1(42'h3FFFFFFFFFF, 5'd31, 1'b1, 3'd6),
    mk1(42'h10,         5'd2,  1'b1, 3'd7),
    mk1(42'h20,         5'd4,  1'b1, 3'd1),
    mk1(42'h30,         5'd5,  1'b0, 3'd2)
  };
  localparam logic [NV-1:0] E_MOVE = 8'b1111_0011;
  localparam logic [NV-1:0] E_REL  = 8'b0111_0101;
  localparam logic [NV-1:0] E_EOP  = 8'b0100_0110;
  localparam logic [14:0] E_BYTES [NV] = '{15'd128, 15'd1024, 15'd1664, 15'd0,
                                           15'd10368, 15'd16384, 15'd256, 15'd512};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tail_we = 1'b0;
  logic [IDX_W-1:0] tail_idx = '0;
  logic mem_rd_en;
  logic [IDX_W:0] mem_rd_addr;
  logic [63:0] mem_rd_data;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [13:0] out_len;
  logic out_move, out_eop, out_nosend, out_csum_en, out_rel, err_malformed;
  logic [7:0] out_csum_start, out_csum_dest;
  logic [15:0] out_csum_seed;
  logic [41:0] out_va;
  logic [4:0] out_stack;
  logic [14:0] out_buf_bytes;

  logic [63:0] ring [2*DEPTH];
  int checks = 0;
  int errors = 0;
  logic [IDX_W-1:0] bh = '0;
  logic bgen = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) if (mem_rd_en) mem_rd_data <= ring[mem_rd_addr];

  desc_ring_consumer #(.IDX_W(IDX_W)) u0 (
    .clk(clk), .rst_n(rst_n), .tail_we(tail_we), .tail_idx(tail_idx),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_len(out_len), .out_move(out_move),
    .out_eop(out_eop), .out_nosend(out_nosend), .out_csum_en(out_csum_en),
    .out_csum_start(out_csum_start), .out_csum_dest(out_csum_dest),
    .out_csum_seed(out_csum_seed), .out_va(out_va), .out_stack(out_stack),
    .out_buf_bytes(out_buf_bytes), .out_rel(out_rel), .err_malformed(err_malformed)
  );

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [63:0] w0, input logic [63:0] w1, input logic g);
    ring[{bh, 1'b0}] = {w0[63:1], g};
    ring[{bh, 1'b1}] = w1;
  endtask

  task automatic bell(input logic [IDX_W-1:0] idx);
    @(negedge clk);
    tail_we = 1'b1;
    tail_idx = idx;
    @(negedge clk);
    tail_we = 1'b0;
  endtask

  task automatic wait_valid(output logic seen);
    seen = 1'b0;
    for (int k = 0; k < 60 && !seen; k++) begin
      @(negedge clk);
      seen = out_valid;
    end
  endtask

  task automatic accept();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    if (bh == IDX_W'(DEPTH - 1)) bgen = ~bgen;
    bh = bh + 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic seen;
    logic [63:0] w0, w1;
    int rd_cnt, v_cnt, e_cnt;
    for (int i = 0; i < 2*DEPTH; i++) ring[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !mem_rd_en && !err_malformed, "R1 reset outputs",
        {61'd0, out_valid, mem_rd_en, err_malformed}, 64'd0);

    put(V_W0[0], V_W1[0], 1'b1);
    rd_cnt = 0; v_cnt = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      rd_cnt += int'(mem_rd_en);
      v_cnt += int'(out_valid);
    end
    chk(rd_cnt == 0 && v_cnt == 0, "R4 no read without doorbell", 64'(rd_cnt + v_cnt), 64'd0);
    bell(bh + 1'b1);
    wait_valid(seen);
    chk(seen && out_len == 14'd100, "R4 doorbell starts fetch (R1 gen 1)", {49'd0, seen, out_len}, {49'd0, 1'b1, 14'd100});
    accept();

    for (int i = 0; i < NV; i++) begin
      w0 = V_W0[i];
      w1 = V_W1[i];
      put(w0, w1, bgen);
      bell(bh + 1'b1);
      wait_valid(seen);
      chk(seen, bgen ? "R2 matching gen consumed" : "R3 second-lap gen 0 consumed", 64'(seen), 64'd1);
      if (seen) begin
        chk(out_len == w0[29:16], "R12 length", 64'(out_len), 64'(w0[29:16]));
        chk(out_move == E_MOVE[i], "R6 R7 move qualifier", 64'(out_move), 64'(E_MOVE[i]));
        chk(out_rel == E_REL[i], "R9 release request", 64'(out_rel), 64'(E_REL[i]));
        chk(out_eop == E_EOP[i], "R5 end of packet", 64'(out_eop), 64'(E_EOP[i]));
        chk(out_nosend == w0[9], "R6 nosend flag", 64'(out_nosend), 64'(w0[9]));
        chk(out_buf_bytes == E_BYTES[i], "R8 buffer bytes", 64'(out_buf_bytes), 64'(E_BYTES[i]));
        chk(out_va == (w0[29:16] != 0 ? w1[41:0] : 42'd0) &&
            out_stack == (w0[29:16] != 0 ? w1[52:48] : 5'd0), "R7 R12 address and stack",
            {17'd0, out_stack, out_va}, {17'd0, (w0[29:16] != 0 ? w1[52:48] : 5'd0),
            (w0[29:16] != 0 ? w1[41:0] : 42'd0)});
        chk({out_csum_en, out_csum_dest, out_csum_start, out_csum_seed} ==
            {w0[8], w0[39:32], w0[47:40], w0[63:48]}, "R12 checksum fields",
            {31'd0, out_csum_en, out_csum_dest, out_csum_start, out_csum_seed},
            {31'd0, w0[8], w0[39:32], w0[47:40], w0[63:48]});
        if (i == 1) begin
          repeat (6) @(negedge clk);
          chk(out_valid && out_len == w0[29:16] && out_eop, "R11 held under back-pressure",
              {48'd0, out_valid, out_eop, out_len}, {48'd0, 2'b11, w0[29:16]});
        end
        accept();
      end
    end

    put(V_W0[0], V_W1[0], ~bgen);
    bell(bh + 1'b1);
    v_cnt = 0;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      v_cnt += int'(out_valid);
    end
    chk(v_cnt == 0, "R2 stale gen ignored", 64'(v_cnt), 64'd0);
    @(negedge clk);
    put(V_W0[6], V_W1[6], bgen);
    wait_valid(seen);
    chk(seen && out_len == 14'd200, "R2 entry accepted once gen matches", {49'd0, seen, out_len}, {49'd0, 1'b1, 14'd200});
    accept();

    put(mk0(1'b0, 1'b0, 1'b1, 14'd40, 8'd0, 8'd0, 16'h0001), V_W1[0], bgen);
    bell(bh + 1'b1);
    v_cnt = 0; e_cnt = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      v_cnt += int'(out_valid);
      e_cnt += int'(err_malformed);
    end
    chk(e_cnt == 1 && v_cnt == 0, "R10 malformed flagged once and dropped",
        {32'(e_cnt), 32'(v_cnt)}, {32'd1, 32'd0});
    if (bh == IDX_W'(DEPTH - 1)) bgen = ~bgen;
    bh = bh + 1'b1;
    put(V_W0[4], V_W1[4], bgen);
    bell(bh + 1'b1);
    wait_valid(seen);
    chk(seen && out_len == 14'd16383, "R10 head advanced past dropped entry",
        {49'd0, seen, out_len}, {49'd0, 1'b1, 14'd16383});
    accept();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule